// File: doc/BRIEF.md
# Display Receiver Pixel Output Conditioner

This block sits between a link deserializer and the pixel pins of a display receiver. On every pixel clock it takes one decoded word: 24 colour bits, the three control bits (data enable, vertical sync and horizontal sync) and an odd parity bit. It checks the parity of each word. A word that fails the check is flagged on an error output, and the pixel last known to be good is sent in its place.

The control bits pass through a minimum-width filter, so short glitches never reach the panel. The colour path is delayed by the same number of cycles as the filter, which keeps colour, controls and the error flag aligned. A mode input selects full 8-bit channels or 6-bit channels packed at the low end. An active-low wake input puts the block to sleep. While asleep, the outputs are held at zero and all history is cleared.

Top module: `pixel_out_conditioner`

## Requirements
- R1: While `rstN` is low, every output is 0 after the next rising clock edge.
- R2: A word is good when the XOR of its 24 colour bits, the three control bits and `inParity` equals 1. `errOut` is high in the same output cycle as the flagged word, which is 3 clock edges after the word is sampled. It is low for good words.
- R3: A word with bad parity is replaced by the most recent good word, colour and control bits both. Before any good word has arrived, the replacement is all zeros.
- R4: A control pulse (`inDe`, `inVs` or `inHs`) of 1 or 2 cycles, high or low, has no effect on the matching output.
- R5: A control output takes a new level only after 3 consecutive words carry that level. The change appears 3 edges after the first of those words is sampled. The filtered outputs start low.
- R6: With `mode24` high, the colour output is the word's colour 3 edges after it is sampled. Red comes from `inColor[23:16]`, green from `[15:8]` and blue from `[7:0]`, with bit 7 as the MSB.
- R7: With `mode24` low, each channel outputs its bits 5 to 0 unchanged and drives bits 7 and 6 to 0.
- R8: While `awake` is low, all outputs are 0 after the next edge. The last-good word and the delay stages are also cleared, so after waking the block behaves as it does after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| awake | input | 1 | Low puts the block to sleep |
| mode24 | input | 1 | High: 8-bit channels; low: 6-bit channels |
| inColor | input | 24 | Decoded colour: red, green, blue from MSB down |
| inDe | input | 1 | Decoded data enable |
| inVs | input | 1 | Decoded vertical sync |
| inHs | input | 1 | Decoded horizontal sync |
| inParity | input | 1 | Odd parity bit of the word |
| outRed | output | 8 | Red channel |
| outGreen | output | 8 | Green channel |
| outBlue | output | 8 | Blue channel |
| outDe | output | 1 | Filtered data enable |
| outVs | output | 1 | Filtered vertical sync |
| outHs | output | 1 | Filtered horizontal sync |
| errOut | output | 1 | High for a substituted word |

## Verification
The bench uses control pulses of exactly 1, 2 and 3 cycles. A filter off by one cycle would either let a 2-cycle glitch through or swallow a legal 3-cycle pulse. It sends a bad word directly after a good one, and a bad word as the very first word after reset and after waking. A design that forwarded the bad word, or kept stale history across sleep, would show wrong colour. In 18-bit mode it drives all-ones colour, so an unmasked upper bit shows up. Random control runs and random parity faults then test the 3-cycle alignment of colour, controls and the error flag together.

// File: rtl/pix_cond_pkg.sv
package pix_cond_pkg;
  parameter int CHAN_W   = 8;
  parameter int NARROW_W = 6;
  parameter int NUM_CTL  = 3;
  localparam int COLOR_W = 3 * CHAN_W;

  // one delayed pixel word
  typedef struct packed {
    logic [COLOR_W-1:0] color;
    logic [NUM_CTL-1:0] ctl;
    logic               err;
  } pixStage_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               goodWord;
    logic               clearAll;
    logic [NUM_CTL-1:0] ctlLoad;
  } condStrobes_t;
endpackage

// File: rtl/pix_cond_control.sv
module pix_cond_control
  import pix_cond_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic                              awake,
  input  logic [COLOR_W-1:0]                inColor,
  input  logic [NUM_CTL-1:0]                inCtl,
  input  logic                              inParity,
  input  logic [FILT_LEN-1:0][NUM_CTL-1:0]  ctlHist,
  output condStrobes_t                      strb
);
  logic [NUM_CTL-1:0] allHigh;
  logic [NUM_CTL-1:0] allLow;

  always_comb begin
    allHigh = '1;
    allLow  = '1;
    for (int k = 0; k < FILT_LEN; k++) begin
      allHigh = allHigh & ctlHist[k];
      allLow  = allLow & ~ctlHist[k];
    end
  end

  always_comb begin
    strb.goodWord = ^{inColor, inCtl, inParity};
    strb.clearAll = !awake;
    strb.ctlLoad  = allHigh | allLow;
  end
endmodule

// File: rtl/pix_cond_datapath.sv
module pix_cond_datapath
  import pix_cond_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              mode24,
  input  logic [COLOR_W-1:0]                inColor,
  input  logic [NUM_CTL-1:0]                inCtl,
  input  condStrobes_t                      strb,
  output logic [FILT_LEN-1:0][NUM_CTL-1:0]  ctlHist,
  output logic [COLOR_W-1:0]                outColor,
  output logic [NUM_CTL-1:0]                outCtl,
  output logic                              errOut
);
  localparam int LAST = FILT_LEN - 1;

  pixStage_t          pipe [FILT_LEN];
  logic [COLOR_W-1:0] lastColor;
  logic [NUM_CTL-1:0] lastCtl;
  logic [COLOR_W-1:0] mapped;

  generate
    for (genvar k = 0; k < FILT_LEN; k++) begin : g_hist
      assign ctlHist[k] = pipe[k].ctl;
    end
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      assign mapped[ch*CHAN_W +: CHAN_W] = mode24
        ? pipe[LAST].color[ch*CHAN_W +: CHAN_W]
        : {{(CHAN_W-NARROW_W){1'b0}}, pipe[LAST].color[ch*CHAN_W +: NARROW_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      for (int k = 0; k < FILT_LEN; k++) pipe[k] <= '0;
      lastColor <= '0;
      lastCtl   <= '0;
      outColor  <= '0;
      outCtl    <= '0;
      errOut    <= 1'b0;
    end else begin
      if (strb.goodWord) begin
        lastColor <= inColor;
        lastCtl   <= inCtl;
      end
      pipe[0].color <= strb.goodWord ? inColor : lastColor;
      pipe[0].ctl   <= strb.goodWord ? inCtl : lastCtl;
      pipe[0].err   <= !strb.goodWord;
      for (int k = 1; k < FILT_LEN; k++) pipe[k] <= pipe[k-1];
      outColor <= mapped;
      errOut   <= pipe[LAST].err;
      for (int i = 0; i < NUM_CTL; i++)
        if (strb.ctlLoad[i]) outCtl[i] <= pipe[0].ctl[i];
    end
  end
endmodule

// File: rtl/pixel_out_conditioner.sv
module pixel_out_conditioner
  import pix_cond_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               awake,
  input  logic               mode24,
  input  logic [COLOR_W-1:0] inColor,
  input  logic               inDe,
  input  logic               inVs,
  input  logic               inHs,
  input  logic               inParity,
  output logic [CHAN_W-1:0]  outRed,
  output logic [CHAN_W-1:0]  outGreen,
  output logic [CHAN_W-1:0]  outBlue,
  output logic               outDe,
  output logic               outVs,
  output logic               outHs,
  output logic               errOut
);
  condStrobes_t                     strb;
  logic [FILT_LEN-1:0][NUM_CTL-1:0] ctlHist;
  logic [COLOR_W-1:0]               outColor;
  logic [NUM_CTL-1:0]               outCtl;

  pix_cond_control #(.FILT_LEN(FILT_LEN)) i_ctrl (
    .awake   (awake),
    .inColor (inColor),
    .inCtl   ({inDe, inVs, inHs}),
    .inParity(inParity),
    .ctlHist (ctlHist),
    .strb    (strb)
  );

  pix_cond_datapath #(.FILT_LEN(FILT_LEN)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .mode24  (mode24),
    .inColor (inColor),
    .inCtl   ({inDe, inVs, inHs}),
    .strb    (strb),
    .ctlHist (ctlHist),
    .outColor(outColor),
    .outCtl  (outCtl),
    .errOut  (errOut)
  );

  assign {outRed, outGreen, outBlue} = outColor;
  assign {outDe, outVs, outHs}       = outCtl;
endmodule

// File: rtl/pix_cond_checker.sv
module pix_cond_checker
  import pix_cond_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              awake,
  input logic              mode24,
  input logic [CHAN_W-1:0] outRed,
  input logic [CHAN_W-1:0] outGreen,
  input logic [CHAN_W-1:0] outBlue,
  input logic              outDe,
  input logic              outVs,
  input logic              outHs,
  input logic              errOut
);
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !awake |=> ({outRed, outGreen, outBlue, outDe, outVs, outHs, errOut} == '0)); // R8

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mode24 |=> (outRed[CHAN_W-1:NARROW_W] == '0 && outGreen[CHAN_W-1:NARROW_W] == '0
                 && outBlue[CHAN_W-1:NARROW_W] == '0)); // R7

  AST_DE_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outDe) && awake) |=> outDe); // R5

  AST_DE_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outDe) && awake) |=> !outDe); // R4

  AST_VS_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outVs) && awake) |=> outVs); // R5

  AST_HS_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outHs) && awake) |=> outHs); // R5
endmodule

bind pixel_out_conditioner pix_cond_checker i_checker (
  .clk(clk), .rstN(rstN), .awake(awake), .mode24(mode24),
  .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue),
  .outDe(outDe), .outVs(outVs), .outHs(outHs), .errOut(errOut)
);

// File: tb/test_pixel_out_conditioner.sv
module test_pixel_out_conditioner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        awake = 1'b1;
  logic        mode24 = 1'b1;
  logic [23:0] inColor = '0;
  logic        inDe = 1'b0, inVs = 1'b0, inHs = 1'b0, inParity = 1'b1;
  logic [7:0]  outRed, outGreen, outBlue;
  logic        outDe, outVs, outHs, errOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int deSeen = 0;

  // reference state built from the requirements
  logic [23:0] mCol [3];
  logic [2:0]  mCtl [3];
  logic        mErr [3];
  logic [23:0] lgCol;
  logic [2:0]  lgCtl;
  logic [2:0]  expCtl;
  logic [23:0] expCol;
  logic        expErr;
  logic        expMode;

  pixel_out_conditioner i_pixel_out_conditioner (
    .clk(clk), .rstN(rstN), .awake(awake), .mode24(mode24),
    .inColor(inColor), .inDe(inDe), .inVs(inVs), .inHs(inHs), .inParity(inParity),
    .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue),
    .outDe(outDe), .outVs(outVs), .outHs(outHs), .errOut(errOut)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] mapColor(logic [23:0] c, logic m24);
    return m24 ? c : (c & 24'h3F3F3F);
  endfunction

  task automatic modelEdge();
    logic       good;
    logic [2:0] ctlNow;
    ctlNow = {inDe, inVs, inHs};
    if (!rstN || !awake) begin
      for (int k = 0; k < 3; k++) begin mCol[k] = '0; mCtl[k] = '0; mErr[k] = 1'b0; end
      lgCol = '0; lgCtl = '0; expCtl = '0; expCol = '0; expErr = 1'b0;
    end else begin
      good   = ^{inColor, ctlNow, inParity};
      expCol = mapColor(mCol[2], mode24);
      expErr = mErr[2];
      for (int i = 0; i < 3; i++)
        if (mCtl[0][i] == mCtl[1][i] && mCtl[1][i] == mCtl[2][i]) expCtl[i] = mCtl[0][i];
      mCol[2] = mCol[1]; mCtl[2] = mCtl[1]; mErr[2] = mErr[1];
      mCol[1] = mCol[0]; mCtl[1] = mCtl[0]; mErr[1] = mErr[0];
      mCol[0] = good ? inColor : lgCol;
      mCtl[0] = good ? ctlNow : lgCtl;
      mErr[0] = !good;
      if (good) begin lgCol = inColor; lgCtl = ctlNow; end
    end
    expMode = mode24;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    if (!awake) check("R8", {outRed, outGreen, outBlue, outDe, outVs, outHs, errOut}, '0);
    else begin
      check(expMode ? "R6" : "R7", {outRed, outGreen, outBlue}, expCol);
      check("R2", errOut, expErr);
      check("R4 R5", {outDe, outVs, outHs}, expCtl);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    if (outDe) deSeen++;
    compareAll();
  endtask

  task automatic drive(logic [23:0] c, logic [2:0] ctl, bit bad);
    inColor = c;
    {inDe, inVs, inHs} = ctl;
    inParity = ~(^{c, ctl}) ^ bad;
  endtask

  task automatic pulseDe(int w, int expHigh);
    for (int k = 0; k < 4; k++) begin drive(24'h102030, 3'b000, 0); step(); end
    deSeen = 0;
    for (int k = 0; k < w; k++) begin drive(24'h405060, 3'b100, 0); step(); end
    for (int k = 0; k < 8; k++) begin drive(24'h708090, 3'b000, 0); step(); end
    check(w < 3 ? "R4" : "R5", deSeen, expHigh);
  endtask

  initial begin
    int runLeft [3];
    logic [2:0] lvl;
    void'($urandom(32'd4242));
    @(negedge clk);
    for (int k = 0; k < 3; k++) step();
    check("R1", {outRed, outGreen, outBlue, outDe, outVs, outHs, errOut}, '0);
    rstN = 1'b1;

    // R3: bad word first after reset becomes zeros
    drive(24'hABCDEF, 3'b111, 1); step();
    for (int k = 0; k < 3; k++) begin drive(24'h010101, 3'b000, 0); step(); end
    check("R3", {outRed, outGreen, outBlue}, 24'h0);
    check("R2", errOut, 1'b1);

    // R3: bad word after a good one repeats the good one
    drive(24'h123456, 3'b000, 0); step();
    drive(24'hFEDCBA, 3'b000, 1); step();
    for (int k = 0; k < 3; k++) begin drive(24'h777777, 3'b000, 0); step(); end
    check("R3", {outRed, outGreen, outBlue}, 24'h123456);
    check("R2", errOut, 1'b1);
    step();
    check("R2", errOut, 1'b0);

    // R4/R5 glitch widths
    pulseDe(1, 0);
    pulseDe(2, 0);
    pulseDe(3, 3);

    // R7 narrow mode masking
    mode24 = 1'b0;
    for (int k = 0; k < 4; k++) begin drive(24'hFFFFFF, 3'b000, 0); step(); end
    check("R7", {outRed, outGreen, outBlue}, 24'h3F3F3F);
    mode24 = 1'b1;

    // random phase
    lvl = 3'b000;
    for (int i = 0; i < 3; i++) runLeft[i] = 1;
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) mode24 = 1'b0;
      if (n == 3000) mode24 = 1'b1;
      for (int i = 0; i < 3; i++) begin
        runLeft[i]--;
        if (runLeft[i] <= 0) begin
          lvl[i] = ~lvl[i];
          runLeft[i] = $urandom_range(1, 6);
        end
      end
      drive($urandom, lvl, ($urandom_range(0, 99) < 12));
      step();
    end

    // R8 sleep clears outputs and history
    drive(24'h5A5A5A, 3'b111, 0);
    for (int k = 0; k < 4; k++) step();
    awake = 1'b0;
    step();
    check("R8", {outRed, outGreen, outBlue, outDe, outVs, outHs, errOut}, '0);
    step();
    awake = 1'b1;
    drive(24'h999999, 3'b111, 1); step();
    for (int k = 0; k < 3; k++) begin drive(24'h222222, 3'b000, 0); step(); end
    check("R8", {outRed, outGreen, outBlue}, 24'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule